// File: doc/BRIEF.md
# Serial Port Frame Timing Master

This block drives the clocked side of a synchronous serial link to a host signal processor. It derives a bit clock from the system clock by a fixed division. It groups those bit clocks into long frames and marks each frame with an active-low frame sync. In every frame one parallel transmit word is shifted out and one word is collected from the serial input, most significant bit first.

Two strap inputs shape the link. The frame-sync strap picks between a short sync pulse that comes one bit period ahead of the data and a long sync that frames the data bits like a chip select. This strap is captured during reset and then frozen. The clock strap picks a free-running bit clock or a burst of a fixed number of bit clocks at the head of each frame. The received word is handed over with a one-cycle strobe.

Top module: `sport_frame_master`

## Requirements
- R1: In free-running mode the bit clock `sclk` has a period of 18 system clocks: high for 9, then low for 9.
- R2: A frame lasts 256 bit clocks, so `fs_n` falls once every 4608 system clocks in both sync styles and both clock modes.
- R3: Early style (`type_strap` 1 when reset is released): `fs_n` falls on the same system edge as the `sclk` rise that opens the sync slot, and stays low for exactly one bit period (18 system clocks). The first data bit follows on the next rise.
- R4: Late style (`type_strap` 0 when reset is released): `fs_n` falls with the `sclk` rise of the first data bit and stays low for the 16 data bits (288 system clocks).
- R5: `type_strap` is captured only while `rst_n` is low. The value it has in the last reset cycle fixes the style, and later changes leave the width of `fs_n` unchanged.
- R6: `sdout` changes only on `sclk` rising edges. It carries `tx_word` MSB first, one bit per data slot, and is 0 outside the data slots.
- R7: `sdin` is sampled on `sclk` falling edges of the 16 data slots, MSB first. After the sixteenth sample, `rx_word` shows the assembled word and `rx_valid` is high for exactly one system clock.
- R8: Burst mode (`sck_cont` low): each frame has exactly 32 `sclk` pulses, beginning with the sync slot, and `sclk` stays low for the rest of the frame.
- R9: While `rst_n` is low: `sclk` is 0, `fs_n` is 1, `sdout` is 0, `rx_valid` is 0 and `rx_word` is 0.
- R10: `tx_word` is captured once, at the start of the frame (the sync slot's rising edge). A change to `tx_word` later in that frame does not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; the frame-sync strap is captured while low |
| type_strap | input | 1 | 1 selects early sync pulse, 0 selects late chip-select sync |
| sck_cont | input | 1 | 1 selects free-running bit clock, 0 selects a 32-pulse burst per frame |
| sdin | input | 1 | Serial data from the host |
| tx_word | input | 16 | Word to send in the next frame |
| sclk | output | 1 | Serial bit clock |
| fs_n | output | 1 | Active-low frame sync |
| sdout | output | 1 | Serial data to the host |
| rx_word | output | 16 | Last received word |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_word` |

## Verification
The bench measures the bit-clock and frame periods, and the sync width in both styles. A slot counter that is off by one would show up as a 17- or 19-cycle bit period, or as a late sync lasting 15 or 17 bits. It moves the frame-sync strap after reset, so a design that keeps following the pin would change the sync width. It changes the transmit word in the middle of a frame, which shows up a design that shifts the live input instead of a copy. It counts the burst pulses, so a gate window that is too long or too short is caught. Data words with an isolated MSB or LSB and alternating patterns expose a reversed bit order or a one-bit shift.

// File: rtl/sport_pkg.sv
package sport_pkg;

  typedef enum logic {
    FS_LATE  = 1'b0,
    FS_EARLY = 1'b1
  } fs_style_e;

  // System clocks in one bit-clock period
  function automatic int bit_sys_cycles(int div);
    return div;
  endfunction

  // System clocks in one frame
  function automatic int frame_sys_cycles(int div, int slots);
    return div * slots;
  endfunction

  // Divider count at which the bit clock falls
  function automatic int fall_point(int div);
    return div / 2;
  endfunction

  // Slot 0 is the sync slot; data occupies slots 1..word_bits
  function automatic logic is_data_slot(int slot, int word_bits);
    return (slot >= 1) && (slot <= word_bits);
  endfunction

endpackage

// File: rtl/sport_clk_div.sv
module sport_clk_div #(
  parameter int DIV = 18
) (
  input  logic clk,
  input  logic rst_n,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW   = $clog2(DIV);
  localparam int HALF = sport_pkg::fall_point(DIV);

  logic [CW-1:0] cnt;

  assign rise_evt = (cnt == CW'(DIV - 1));
  assign fall_evt = (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (rise_evt) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sport_slot_ctr.sv
module sport_slot_ctr #(
  parameter int SLOTS     = 256,
  parameter int WORD_BITS = 16,
  parameter int GATED     = 32,
  localparam int SW       = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_evt,
  input  logic          early,
  output logic [SW-1:0] slot,
  output logic          fs_n,
  output logic          frame_start,
  output logic          data_rise,
  output logic          in_data,
  output logic          gate_ok_nxt
);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic [SW-1:0] slot_nxt;
  logic          nxt_data;
  logic          fs_active_nxt;

  always_comb begin
    slot_nxt      = (slot == LAST) ? '0 : slot + 1'b1;
    nxt_data      = sport_pkg::is_data_slot(int'(slot_nxt), WORD_BITS);
    fs_active_nxt = early ? (slot_nxt == '0) : nxt_data;
  end

  assign frame_start = rise_evt && (slot_nxt == '0);
  assign data_rise   = rise_evt && nxt_data;
  assign in_data     = sport_pkg::is_data_slot(int'(slot), WORD_BITS);
  assign gate_ok_nxt = int'(slot_nxt) < GATED;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= LAST;
      fs_n <= 1'b1;
    end else if (rise_evt) begin
      slot <= slot_nxt;
      fs_n <= !fs_active_nxt;
    end
  end
endmodule

// File: rtl/sport_tx_shift.sv
module sport_tx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift_evt,
  input  logic         idle_evt,
  input  logic [W-1:0] word_in,
  output logic         sdout
);
  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '0;
      sdout <= 1'b0;
    end else if (load) begin
      sh    <= word_in;
      sdout <= 1'b0;
    end else if (shift_evt) begin
      sdout <= sh[W-1];
      sh    <= {sh[W-2:0], 1'b0};
    end else if (idle_evt) begin
      sdout <= 1'b0;
    end
  end
endmodule

// File: rtl/sport_rx_shift.sv
module sport_rx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample_evt,
  input  logic         last_evt,
  input  logic         sdin,
  output logic [W-1:0] rx_word,
  output logic         rx_valid
);
  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (sample_evt) sh <= {sh[W-2:0], sdin};
      if (last_evt) begin
        rx_word  <= {sh[W-2:0], sdin};
        rx_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sport_frame_master.sv
module sport_frame_master #(
  parameter int DIV        = 18,
  parameter int SLOTS      = 256,
  parameter int WORD_BITS  = 16,
  parameter int GATED_CLKS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 type_strap,
  input  logic                 sck_cont,
  input  logic                 sdin,
  input  logic [WORD_BITS-1:0] tx_word,
  output logic                 sclk,
  output logic                 fs_n,
  output logic                 sdout,
  output logic [WORD_BITS-1:0] rx_word,
  output logic                 rx_valid
);
  localparam int SLOT_W = $clog2(SLOTS);

  // Internal events, named for the checker
  logic              rise_evt, fall_evt;
  logic [SLOT_W-1:0] slot;
  logic              frame_start, data_rise, in_data, gate_ok_nxt;
  logic              data_fall, last_fall, idle_rise;
  sport_pkg::fs_style_e early_q;

  // Sync style is captured on every clock while reset is held, then frozen
  always_ff @(posedge clk) begin
    if (!rst_n) early_q <= sport_pkg::fs_style_e'(type_strap);
  end

  sport_clk_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  sport_slot_ctr #(.SLOTS(SLOTS), .WORD_BITS(WORD_BITS), .GATED(GATED_CLKS)) u_slot (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt),
    .early(early_q == sport_pkg::FS_EARLY),
    .slot(slot), .fs_n(fs_n), .frame_start(frame_start),
    .data_rise(data_rise), .in_data(in_data), .gate_ok_nxt(gate_ok_nxt)
  );

  assign data_fall = fall_evt && in_data;
  assign last_fall = data_fall && (slot == SLOT_W'(WORD_BITS));
  assign idle_rise = rise_evt && !data_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sclk <= 1'b0;
    else if (rise_evt) sclk <= sck_cont || gate_ok_nxt;
    else if (fall_evt) sclk <= 1'b0;
  end

  sport_tx_shift #(.W(WORD_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(frame_start), .shift_evt(data_rise),
    .idle_evt(idle_rise), .word_in(tx_word), .sdout(sdout)
  );

  sport_rx_shift #(.W(WORD_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .sample_evt(data_fall), .last_evt(last_fall),
    .sdin(sdin), .rx_word(rx_word), .rx_valid(rx_valid)
  );
endmodule

// File: rtl/sport_frame_master_chk.sv
module sport_frame_master_chk #(
  parameter int DIV       = 18,
  parameter int WORD_BITS = 16,
  parameter int GATED     = 32,
  parameter int SLOT_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk,
  input logic              fs_n,
  input logic              sdout,
  input logic              rx_valid,
  input logic              sck_cont,
  input logic              early_q,
  input logic [SLOT_W-1:0] slot
);
  int   since_rise;
  int   low_len;
  logic sclk_d;
  logic seen_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rise <= 0;
      low_len    <= 0;
      sclk_d     <= 1'b0;
      seen_rise  <= 1'b0;
    end else begin
      sclk_d  <= sclk;
      low_len <= fs_n ? 0 : low_len + 1;
      if (sclk && !sclk_d) begin
        since_rise <= 1;
        seen_rise  <= 1'b1;
      end else begin
        since_rise <= since_rise + 1;
      end
    end
  end

  assert_bit_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) && seen_rise && sck_cont) |-> (since_rise == DIV));

  assert_early_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fs_n) && early_q) |-> (low_len == DIV));

  assert_late_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fs_n) && !early_q) |-> (low_len == DIV * WORD_BITS));

  assert_style_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(early_q));

  assert_sdout_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout) |-> $rose(sclk));

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_burst_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_cont && $rose(sclk)) |-> (int'(slot) < GATED));
endmodule

bind sport_frame_master sport_frame_master_chk #(
  .DIV(DIV), .WORD_BITS(WORD_BITS), .GATED(GATED_CLKS), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .fs_n(fs_n), .sdout(sdout),
  .rx_valid(rx_valid), .sck_cont(sck_cont), .early_q(early_q), .slot(slot)
);

// File: tb/tb_sport_frame_master.sv
module tb_sport_frame_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 18;
  localparam int SLOTS = 256;
  localparam int W = 16;
  localparam int NVEC = 6;
  // {tx word, word the host sends}
  localparam logic [31:0] VEC [NVEC] = '{
    32'h8000_0001, 32'h0001_8000, 32'hA5A5_5A5A,
    32'hFFFF_0000, 32'h0000_FFFF, 32'h1234_C3E7
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic type_strap = 1'b1;
  logic sck_cont = 1'b1;
  logic sdin = 1'b0;
  logic [W-1:0] tx_word = '0;
  logic sclk, fs_n, sdout, rx_valid;
  logic [W-1:0] rx_word;

  int checks = 0;
  int errors = 0;
  int rise_cnt = 0;

  sport_frame_master dut (
    .clk(clk), .rst_n(rst_n), .type_strap(type_strap), .sck_cont(sck_cont),
    .sdin(sdin), .tx_word(tx_word), .sclk(sclk), .fs_n(fs_n), .sdout(sdout),
    .rx_word(rx_word), .rx_valid(rx_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge sclk) rise_cnt++;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic ty, input logic sc);
    @(negedge clk);
    rst_n = 1'b0;
    type_strap = ty;
    sck_cont = sc;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One frame: sends rxv to the design, returns the bits seen on sdout
  task automatic xfer(input logic late, input logic [W-1:0] rxv, input logic scramble,
                      output logic [W-1:0] got, output logic [W-1:0] rcv, output logic one_shot);
    got = '0;
    @(negedge fs_n);
    #1;
    for (int k = 0; k < W; k++) begin
      if (!(late && k == 0)) begin
        @(posedge sclk);
        #1;
      end
      got = {got[W-2:0], sdout};
      sdin = rxv[W-1-k];
      if (scramble && k == 3) tx_word = ~tx_word;
    end
    @(posedge rx_valid);
    #1;
    rcv = rx_word;
    @(posedge clk);
    #1;
    one_shot = !rx_valid;
  endtask

  task automatic fs_low_width(output int cyc);
    time t0;
    @(negedge fs_n);
    t0 = $time;
    @(posedge fs_n);
    cyc = int'(($time - t0) / CLK_PERIOD);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    time t0, t1, t2;
    int n;
    logic [W-1:0] got, rcv;
    logic one;
    logic low_ok;

    // R9: reset state, early style, free-running clock
    do_reset(1'b1, 1'b1);
    rst_n = 1'b0;
    tx_word = 16'h0000;
    #1;
    check(sclk == 1'b0, "R9 sclk", 32'(sclk), 0);
    check(fs_n == 1'b1, "R9 fs_n", 32'(fs_n), 1);
    check(sdout == 1'b0, "R9 sdout", 32'(sdout), 0);
    check(rx_valid == 1'b0, "R9 rx_valid", 32'(rx_valid), 0);
    check(rx_word == '0, "R9 rx_word", 32'(rx_word), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: bit-clock period and high time
    @(posedge sclk); t0 = $time;
    @(negedge sclk); t1 = $time;
    @(posedge sclk); t2 = $time;
    check((t2 - t0) == DIV * CLK_PERIOD, "R1 period", 32'((t2 - t0) / CLK_PERIOD), DIV);
    check((t1 - t0) == (DIV / 2) * CLK_PERIOD, "R1 high", 32'((t1 - t0) / CLK_PERIOD), DIV / 2);

    // R2: frame period; R3: early sync aligned with sclk rise and one bit wide
    @(negedge fs_n); t0 = $time;
    #1;
    check(sclk == 1'b1, "R3 sync aligned with sclk rise", 32'(sclk), 1);
    @(negedge fs_n); t1 = $time;
    check((t1 - t0) == DIV * SLOTS * CLK_PERIOD, "R2 frame period", 32'((t1 - t0) / CLK_PERIOD), DIV * SLOTS);
    fs_low_width(n);
    check(n == DIV, "R3 early width", 32'(n), DIV);

    // R6 R7: vector table, early style
    for (int i = 0; i < NVEC; i++) begin
      tx_word = VEC[i][31:16];
      xfer(1'b0, VEC[i][15:0], 1'b0, got, rcv, one);
      check(got == VEC[i][31:16], "R6 sdout word", 32'(got), 32'(VEC[i][31:16]));
      check(rcv == VEC[i][15:0], "R7 rx_word", 32'(rcv), 32'(VEC[i][15:0]));
      check(one, "R7 strobe one cycle", 32'(one), 1);
    end

    // R10: tx_word changed mid-frame
    tx_word = 16'h6C39;
    xfer(1'b0, 16'h0F0F, 1'b1, got, rcv, one);
    check(got == 16'h6C39, "R10 word held", 32'(got), 32'h6C39);

    // R5: strap change after reset ignored (early stays early)
    type_strap = 1'b0;
    fs_low_width(n);
    check(n == DIV, "R5 early kept", 32'(n), DIV);

    // R4: late style
    do_reset(1'b0, 1'b1);
    tx_word = 16'h8421;
    xfer(1'b1, 16'hBEEF, 1'b0, got, rcv, one);
    check(got == 16'h8421, "R4 late sdout", 32'(got), 32'h8421);
    check(rcv == 16'hBEEF, "R4 late rx", 32'(rcv), 32'hBEEF);
    type_strap = 1'b1;
    fs_low_width(n);
    check(n == DIV * W, "R4 late width", 32'(n), DIV * W);
    check(n == DIV * W, "R5 late kept", 32'(n), DIV * W);

    // R8: burst clock mode
    do_reset(1'b1, 1'b0);
    tx_word = 16'h7E81;
    xfer(1'b0, 16'h4002, 1'b0, got, rcv, one);
    check(got == 16'h7E81, "R8 burst sdout", 32'(got), 32'h7E81);
    check(rcv == 16'h4002, "R8 burst rx", 32'(rcv), 32'h4002);
    @(negedge fs_n); t0 = $time; n = rise_cnt;
    repeat (40 * DIV) @(posedge clk);
    low_ok = 1'b1;
    for (int c = 0; c < 2 * DIV; c++) begin
      @(negedge clk);
      if (sclk) low_ok = 1'b0;
    end
    check(low_ok, "R8 sclk idle low", 32'(low_ok), 1);
    @(negedge fs_n); t1 = $time;
    check(rise_cnt - n == 32, "R8 pulses per frame", 32'(rise_cnt - n), 32);
    check((t1 - t0) == DIV * SLOTS * CLK_PERIOD, "R2 burst frame period", 32'((t1 - t0) / CLK_PERIOD), DIV * SLOTS);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule